// File: doc/BRIEF.md
# Link Test Pattern Engine

This block supplies 120-bit test frames to a serial link transmitter and measures bit errors on frames coming back from the receiver. One frame is produced on every edge of the frame clock. Every frame starts with a constant 4-bit header, followed by one of three payloads chosen by a mode input:
- a constant alternating A/B hex pattern;
- a set of copies of a free-running frame counter;
- sixteen identical lanes of a 7-bit pseudo-random sequence.

The checker side takes received frames qualified by a valid strobe. It compares their 116 payload bits against the constant pattern and adds the number of differing bits to an error counter. That counter stops at all ones and can be cleared synchronously. The checker only understands the constant pattern, so a link under test is normally looped back while the generator runs in constant mode.

The frame counter and the pseudo-random state advance on every frame, whatever the mode. The mode input selects only which payload is placed into the next registered frame.

Top module: `link_pattern_engine`

## Requirements
- R1: While reset is asserted, `tx_frame` is all zeros and `err_count` is zero.
- R2: Every frame produced after reset carries the header 4'b0101 in bits [119:116], in every mode.
- R3: In mode 0 and in mode 3, bits [115:0] of the frame hold the constant 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB.
- R4: In mode 1, the frame holds the 30-bit frame count as follows:
  - its low 26 bits sit in [115:90];
  - the full count sits in each of [89:60], [59:30] and [29:0].
  - The count is 0 in the first frame after reset and rises by one per frame in every mode, modulo 2^30.
- R5: In mode 2, the frame holds the 7-bit generator state as follows:
  - bits [115:112] are zero;
  - lane i, bits [7i+6:7i] for i = 0..15, carries the generator state.
  - The state is 7'h01 in the first frame after reset and never zero.
  - Between consecutive frames the state takes seven steps of s <= {s[5:0], s[6]^s[5]}. This is the polynomial x^7+x^6+1.
  - The state advances in every mode.
- R6: A mode value present at a clock edge sets the payload of the frame that this edge registers. A mode change therefore shows on `tx_frame` one edge later.
- R7: At an edge where `rx_valid` is high and `err_clear` is low, `err_count` grows by the number of ones in (rx_frame[115:0] XOR the R3 constant). The header bits [119:116] of the received frame are not counted.
- R8: At an edge where both `rx_valid` and `err_clear` are low, `err_count` keeps its value, whatever `rx_frame` holds.
- R9: `err_count` saturates at all ones and then stays there until cleared.
- R10: At an edge where `err_clear` is high, `err_count` becomes zero, even when `rx_valid` is also high at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock, one frame per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Payload select: 0 and 3 constant, 1 counter, 2 pseudo-random |
| tx_frame | output | 120 | Registered transmit test frame |
| rx_frame | input | 120 | Received frame to be checked |
| rx_valid | input | 1 | Qualifies `rx_frame` for error counting |
| err_clear | input | 1 | Synchronous clear of the error counter |
| err_count | output | ERR_W (default 32) | Saturating count of mismatched payload bits |

## Verification
Saturation is the situation hardest to reach from the ports. Even with every payload bit wrong, a 32-bit counter needs about 37 million frames to fill. The bench therefore builds the block with a 12-bit error counter and feeds fully inverted payloads, so the limit is reached after 36 frames; it then checks that the counter holds at the limit and clears cleanly. The pseudo-random lanes are checked against a model stepped from reset in lockstep with the frame count. Mode changes are placed on single frames so that the one-edge latency of the payload select is visible.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  localparam int FRAME_W = 120;
  localparam int HDR_W   = 4;
  localparam int PAY_W   = FRAME_W - HDR_W;
  localparam int PRBS_W  = 7;

  localparam logic [HDR_W-1:0] HEADER    = 4'b0101;
  localparam logic [PAY_W-1:0] FIXED_PAY = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;

  typedef enum logic [1:0] {
    PAT_FIXED     = 2'd0,
    PAT_COUNT     = 2'd1,
    PAT_PRBS      = 2'd2,
    PAT_FIXED_ALT = 2'd3
  } pat_mode_e;

endpackage

// File: rtl/lpe_prbs_gen.sv
module lpe_prbs_gen
  import lpe_pkg::*;
#(
  parameter int                STEPS = PRBS_W,
  parameter logic [PRBS_W-1:0] SEED  = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PRBS_W-1:0] state_o
);

  logic [PRBS_W-1:0] state_q;
  logic [PRBS_W-1:0] state_d;
  logic [PRBS_W-1:0] chain [0:STEPS];

  assign chain[0] = state_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = {chain[g][PRBS_W-2:0], chain[g][6] ^ chain[g][5]};
  end

  always_comb begin
    state_d = chain[STEPS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R5
  prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/lpe_frame_gen.sv
module lpe_frame_gen
  import lpe_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pat_mode_e          mode_i,
  output logic [FRAME_W-1:0] tx_frame_o
);

  localparam int FIRST_W = PAY_W - 3 * CNT_W;
  localparam int LANE_TW = LANES * PRBS_W;
  localparam int PAD_W   = PAY_W - LANE_TW;

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_d;
  logic [PRBS_W-1:0]  prbs_val;
  logic [LANE_TW-1:0] lane_bus;
  logic [PAY_W-1:0]   pay_cnt;
  logic [PAY_W-1:0]   pay_prbs;
  logic [PAY_W-1:0]   pay_sel;
  logic [FRAME_W-1:0] tx_d;
  logic [FRAME_W-1:0] tx_q;

  lpe_prbs_gen #(
    .STEPS (PRBS_W),
    .SEED  (7'h01)
  ) i_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (prbs_val)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bus[g*PRBS_W +: PRBS_W] = prbs_val;
  end

  always_comb begin
    cnt_d    = cnt_q + 1'b1;
    pay_cnt  = {cnt_q[FIRST_W-1:0], cnt_q, cnt_q, cnt_q};
    pay_prbs = {{PAD_W{1'b0}}, lane_bus};
    case (mode_i)
      PAT_COUNT: pay_sel = pay_cnt;
      PAT_PRBS:  pay_sel = pay_prbs;
      default:   pay_sel = FIXED_PAY;
    endcase
    tx_d = {HEADER, pay_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      tx_q  <= tx_d;
    end
  end

  assign tx_frame_o = tx_q;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == PAT_COUNT && $past(mode_i, 2) == PAT_COUNT &&
     $past(tx_q[FRAME_W-1 -: HDR_W]) == HEADER)
    |-> tx_q[CNT_W-1:0] == $past(tx_q[CNT_W-1:0]) + 1'b1);

  // R2
  hdr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_q[FRAME_W-1 -: HDR_W]) == HEADER |-> tx_q[FRAME_W-1 -: HDR_W] == HEADER);

endmodule

// File: rtl/lpe_err_checker.sv
module lpe_err_checker
  import lpe_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] rx_frame_i,
  input  logic               rx_valid_i,
  input  logic               clear_i,
  output logic [ERR_W-1:0]   err_count_o
);

  localparam int POP_W = $clog2(PAY_W + 1);

  function automatic logic [POP_W-1:0] count_ones(input logic [PAY_W-1:0] v);
    logic [POP_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < PAY_W; i++) acc = acc + POP_W'(v[i]);
    return acc;
  endfunction

  logic [PAY_W-1:0] diff;
  logic [POP_W-1:0] bit_errs;
  logic [ERR_W:0]   sum;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_d;
  logic             err_en;

  always_comb begin
    diff     = rx_frame_i[PAY_W-1:0] ^ FIXED_PAY;
    bit_errs = count_ones(diff);
    sum      = {1'b0, err_q} + (ERR_W+1)'(bit_errs);
    err_en   = clear_i | rx_valid_i;
    if (clear_i)      err_d = '0;
    else if (sum[ERR_W]) err_d = '1;
    else              err_d = sum[ERR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  assign err_count_o = err_q;

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> err_q == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clear_i) && !$past(rx_valid_i)) |-> $stable(err_q));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_i) |-> err_q >= $past(err_q));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) == '1 && !$past(clear_i)) |-> err_q == '1);

endmodule

// File: rtl/link_pattern_engine.sv
module link_pattern_engine
  import lpe_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int LANES = 16,
  parameter int ERR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  output logic [FRAME_W-1:0] tx_frame,
  input  logic [FRAME_W-1:0] rx_frame,
  input  logic               rx_valid,
  input  logic               err_clear,
  output logic [ERR_W-1:0]   err_count
);

  pat_mode_e mode_e;

  assign mode_e = pat_mode_e'(mode_sel);

  lpe_frame_gen #(
    .CNT_W (CNT_W),
    .LANES (LANES)
  ) i_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_e),
    .tx_frame_o (tx_frame)
  );

  lpe_err_checker #(
    .ERR_W (ERR_W)
  ) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_frame_i  (rx_frame),
    .rx_valid_i  (rx_valid),
    .clear_i     (err_clear),
    .err_count_o (err_count)
  );

endmodule

// File: tb/test_link_pattern_engine.sv
module test_link_pattern_engine;

  localparam int ERR_W = 12;
  localparam logic [115:0] FIX = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;
  localparam logic [3:0]   HDR = 4'b0101;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_sel;
  logic [119:0]     tx_frame;
  logic [119:0]     rx_frame;
  logic             rx_valid;
  logic             err_clear;
  logic [ERR_W-1:0] err_count;

  always #5 clk = ~clk;

  link_pattern_engine #(.ERR_W(ERR_W)) i_link_pattern_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .tx_frame  (tx_frame),
    .rx_frame  (rx_frame),
    .rx_valid  (rx_valid),
    .err_clear (err_clear),
    .err_count (err_count)
  );

  typedef struct {
    logic [119:0]     tx;
    logic [ERR_W-1:0] err;
    string            rtx;
    string            rerr;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  logic [29:0]      m_cnt;
  logic [6:0]       m_prbs;
  logic [ERR_W-1:0] m_err;

  function automatic logic [6:0] prbs_next(input logic [6:0] s);
    logic [6:0] t;
    t = s;
    for (int k = 0; k < 7; k++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction

  function automatic logic [119:0] model_tx(input logic [1:0] md, input logic [29:0] c,
                                            input logic [6:0] p);
    logic [115:0] pay;
    case (md)
      2'd1: pay = {c[25:0], c, c, c};
      2'd2: begin
        pay = '0;
        for (int l = 0; l < 16; l++) pay[l*7 +: 7] = p;
      end
      default: pay = FIX;
    endcase
    return {HDR, pay};
  endfunction

  task automatic check(input bit ok, input string req, input logic [119:0] act,
                       input logic [119:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: called at a negedge, drives one frame and pushes what the next edge must produce
  task automatic frame(input logic [1:0] md, input logic [119:0] rx, input logic vld,
                       input logic clr, input string rtx, input string rerr);
    exp_t e;
    int   sum;
    mode_sel  = md;
    rx_frame  = rx;
    rx_valid  = vld;
    err_clear = clr;
    e.tx = model_tx(md, m_cnt, m_prbs);
    m_cnt  = m_cnt + 1'b1;
    m_prbs = prbs_next(m_prbs);
    if (clr) m_err = '0;
    else if (vld) begin
      sum = int'(m_err) + $countones(rx[115:0] ^ FIX);
      m_err = (sum > int'(ERR_MAX)) ? ERR_MAX : ERR_W'(sum);
    end
    e.err  = m_err;
    e.rtx  = rtx;
    e.rerr = rerr;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(tx_frame == e.tx, e.rtx, tx_frame, e.tx);
      check(err_count == e.err, e.rerr, 120'(err_count), 120'(e.err));
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [119:0] rx;
    rst_n     = 1'b0;
    mode_sel  = 2'd1;
    rx_frame  = '1;
    rx_valid  = 1'b1;
    err_clear = 1'b0;
    m_cnt  = '0;
    m_prbs = 7'h01;
    m_err  = '0;
    repeat (3) @(negedge clk);
    // R1
    check(tx_frame == '0, "R1 tx", tx_frame, '0);
    check(err_count == '0, "R1 err", 120'(err_count), '0);
    rst_n = 1'b1;

    // constant mode, clean loopback, header bits of rx flipped (R7 ignores them)
    frame(2'd0, {HDR, FIX}, 1'b1, 1'b0, "R2 R3", "R7");
    frame(2'd0, {4'b1010, FIX}, 1'b1, 1'b0, "R2 R3", "R7 header");
    rx = {HDR, FIX}; rx[0] = ~rx[0]; rx[115] = ~rx[115]; rx[57] = ~rx[57];
    frame(2'd0, rx, 1'b1, 1'b0, "R3", "R7 three flips");
    // invalid garbage ignored
    frame(2'd0, '1, 1'b0, 1'b0, "R3", "R8");
    frame(2'd0, '0, 1'b0, 1'b0, "R3", "R8");
    // counter mode, R6 on switch
    frame(2'd1, {HDR, FIX}, 1'b0, 1'b0, "R6 R4", "R8");
    for (int i = 0; i < 5; i++) frame(2'd1, '0, 1'b0, 1'b0, "R2 R4", "R8");
    // PRBS mode
    frame(2'd2, {HDR, ~FIX}, 1'b0, 1'b0, "R6 R5", "R8");
    for (int i = 0; i < 20; i++) frame(2'd2, {HDR, FIX}, 1'b1, 1'b0, "R2 R5", "R7");
    // alternate constant mode and one-frame switches
    frame(2'd3, '0, 1'b0, 1'b0, "R6 R3 mode3", "R8");
    frame(2'd1, '0, 1'b0, 1'b0, "R6 R4", "R8");
    frame(2'd2, '0, 1'b0, 1'b0, "R6 R5", "R8");
    frame(2'd0, '0, 1'b0, 1'b0, "R6 R3", "R8");
    // errors then clear, then clear together with valid
    rx = {HDR, FIX}; rx[3:0] = ~rx[3:0];
    frame(2'd0, rx, 1'b1, 1'b0, "R3", "R7 four flips");
    frame(2'd0, rx, 1'b0, 1'b1, "R3", "R10");
    frame(2'd0, rx, 1'b1, 1'b0, "R3", "R7");
    frame(2'd0, {HDR, ~FIX}, 1'b1, 1'b1, "R3", "R10 with valid");
    // saturation
    for (int i = 0; i < 40; i++) frame(2'd1, {HDR, ~FIX}, 1'b1, 1'b0, "R4", "R9");
    frame(2'd1, '0, 1'b0, 1'b0, "R4", "R9 hold");
    frame(2'd1, '0, 1'b0, 1'b1, "R4", "R10 from max");
    frame(2'd2, {HDR, FIX}, 1'b1, 1'b0, "R5", "R7");
    rx_valid  = 1'b0;
    err_clear = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule